// File: doc/BRIEF.md
# Temperature Limit Alarm Controller

This block turns temperature readings into alarms. Two channels feed it: an on-die sensor and an external diode. Each reading is a signed byte. A one-cycle strobe marks each new conversion result, and only a strobed reading is acted on.

On every strobe the block compares the reading against three limits. The high and low limits form a window, and the critical limit sits above it. The result of each comparison is kept in a sticky status flag. The host clears a flag by reading status, and only after the condition behind it has gone away.

A warning output is asserted while any flag is set. A shutdown output is asserted when a channel goes past its critical limit. It is released only after the reading falls below the critical limit minus a hysteresis amount. Each output has its own mask, and a shared setting picks the active level. A qualification option can be enabled for the external channel. It then needs three strobed out-of-limit readings in a row before a flag is set.

Top module: `thermal_alarm_ctrl`

## Requirements
- R1: Readings and limits are two's-complement bytes, 1 °C per LSB. The hot condition is strictly greater than the high limit. The cool condition is strictly less than the low limit. The critical condition is strictly greater than the critical limit.
- R2: The status byte holds these flags: bit 6 local hot, bit 5 local cool, bit 4 remote hot, bit 3 remote cool, bit 2 remote diode open, bit 1 remote critical, bit 0 local critical. Bit 7 always reads 0.
- R3: A hot, cool or critical flag is set only at the clock edge that samples its own channel's strobe. Once set, it holds until a status read clears it. A reading that changes without a strobe has no effect.
- R4: A `status_rd` pulse clears exactly those flags whose condition was false at their channel's most recent strobe. Flags whose condition still holds stay set.
- R5: The shutdown state of a channel sets on a critical reading. It clears only on a strobed reading strictly below (critical limit minus `crit_hyst`). Status reads do not change it.
- R6: While `alert_mask` is 1, `alert_o` shows its inactive level. While `overt_mask` is 1, `overt_o` shows its inactive level. The flags and the shutdown state are kept, so clearing a mask brings the output back.
- R7: With `active_low` = 1, both outputs drive 0 when active. With `active_low` = 0, both outputs drive 1 when active.
- R8: When `fault_queue_en` is 1, each remote condition (hot, cool, critical) sets its flag only on the third consecutive strobed reading that meets the condition. A reading that does not meet it restarts the count. Local readings are never delayed.
- R9: When `rem_open` is 1 at a remote strobe, the remote hot condition is forced true. Status bit 2 follows `rem_open` with one cycle of delay.
- R10: `alert_o` is the OR of all six hot, cool and critical flags. Both outputs and the status byte update at the edge that samples the strobe or the read.
- R11: After synchronous reset, all flags and shutdown states are 0, and both outputs sit at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_valid | input | 1 | New local reading strobe |
| loc_temp | input | 8 | Local reading, signed °C |
| rem_valid | input | 1 | New remote reading strobe |
| rem_temp | input | 8 | Remote reading, signed °C |
| rem_open | input | 1 | Remote diode disconnected |
| loc_hi | input | 8 | Local high limit |
| loc_lo | input | 8 | Local low limit |
| loc_crit | input | 8 | Local critical limit |
| rem_hi | input | 8 | Remote high limit |
| rem_lo | input | 8 | Remote low limit |
| rem_crit | input | 8 | Remote critical limit |
| crit_hyst | input | 5 | Shutdown release hysteresis, °C |
| alert_mask | input | 1 | Mask the warning output |
| overt_mask | input | 1 | Mask the shutdown output |
| fault_queue_en | input | 1 | Require three remote readings in a row |
| active_low | input | 1 | 1: outputs active low, 0: outputs active high |
| status_rd | input | 1 | Status read pulse (read-to-clear) |
| status | output | 8 | Sticky status flags |
| alert_o | output | 1 | Warning output |
| overt_o | output | 1 | Shutdown output |

## Verification
The checker watches a few rules on every cycle:
- A flag rises only at an edge where its own channel's strobe was sampled.
- A flag falls only after a read or a reset.
- A masked output stays at the inactive level for the polarity of the previous cycle.

Some rules need a sequence of readings and can only be shown by the bench's scenarios:
- the signed and strictly-exclusive comparisons at the boundaries;
- the hysteresis band, where equality with the release point keeps shutdown held;
- a restarted three-reading count in the qualification option;
- a read that leaves a still-true flag in place.

// File: rtl/thermal_alarm_pkg.sv
package thermal_alarm_pkg;
  localparam int NUM_CH  = 2;
  localparam int CH_LOC  = 0;
  localparam int CH_REM  = 1;
  localparam int NUM_KIND = 3;
  localparam int K_HOT   = 0;
  localparam int K_COOL  = 1;
  localparam int K_CRIT  = 2;

  typedef struct packed {
    logic hot;
    logic cool;
    logic crit;
    logic below_rel;
  } cmp_t;
endpackage

// File: rtl/limit_compare.sv
module limit_compare
  import thermal_alarm_pkg::*;
#(
  parameter int TW = 8,
  parameter int HW = 5
) (
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] hi,
  input  logic [TW-1:0] lo,
  input  logic [TW-1:0] crit,
  input  logic [HW-1:0] hyst,
  output cmp_t          res
);
  localparam int EW = (TW > HW ? TW : HW) + 2;

  logic signed [EW-1:0] t_e, hi_e, lo_e, cr_e, hy_e, rel_e;

  assign t_e  = {{(EW-TW){temp[TW-1]}}, temp};
  assign hi_e = {{(EW-TW){hi[TW-1]}}, hi};
  assign lo_e = {{(EW-TW){lo[TW-1]}}, lo};
  assign cr_e = {{(EW-TW){crit[TW-1]}}, crit};
  assign hy_e = {{(EW-HW){1'b0}}, hyst};
  assign rel_e = cr_e - hy_e;

  always_comb begin
    res.hot       = t_e > hi_e;
    res.cool      = t_e < lo_e;
    res.crit      = t_e > cr_e;
    res.below_rel = t_e < rel_e;
  end
endmodule

// File: rtl/fault_filter.sv
module fault_filter #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic enable,
  input  logic cond,
  output logic qual
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    if (!cond)             cnt_nxt = '0;
    else if (cnt_q == FULL) cnt_nxt = FULL;
    else                   cnt_nxt = cnt_q + 1'b1;
  end

  assign qual = enable ? (cnt_nxt == FULL) : cond;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (strobe) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/overt_hyst.sv
module overt_hyst (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic set_in,
  input  logic rel_in,
  output logic state_nxt
);
  logic state_q;

  always_comb begin
    state_nxt = state_q;
    if (strobe) begin
      if (set_in)      state_nxt = 1'b1;
      else if (rel_in) state_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= 1'b0;
    else     state_q <= state_nxt;
  end
endmodule

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl
  import thermal_alarm_pkg::*;
#(
  parameter int TW       = 8,
  parameter int HW       = 5,
  parameter int Q_DEPTH  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loc_valid,
  input  logic [TW-1:0] loc_temp,
  input  logic          rem_valid,
  input  logic [TW-1:0] rem_temp,
  input  logic          rem_open,
  input  logic [TW-1:0] loc_hi,
  input  logic [TW-1:0] loc_lo,
  input  logic [TW-1:0] loc_crit,
  input  logic [TW-1:0] rem_hi,
  input  logic [TW-1:0] rem_lo,
  input  logic [TW-1:0] rem_crit,
  input  logic [HW-1:0] crit_hyst,
  input  logic          alert_mask,
  input  logic          overt_mask,
  input  logic          fault_queue_en,
  input  logic          active_low,
  input  logic          status_rd,
  output logic [7:0]    status,
  output logic          alert_o,
  output logic          overt_o
);
  logic [NUM_CH-1:0][NUM_KIND-1:0] flag_q, flag_nxt;
  logic [NUM_CH-1:0]               ov_nxt;
  logic                            open_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam bit IS_REM = (c == CH_REM);
    logic [TW-1:0] t_w, hi_w, lo_w, cr_w;
    logic          valid_w;
    cmp_t          cmp_w;
    logic [NUM_KIND-1:0] raw, qual;

    assign t_w     = IS_REM ? rem_temp  : loc_temp;
    assign hi_w    = IS_REM ? rem_hi    : loc_hi;
    assign lo_w    = IS_REM ? rem_lo    : loc_lo;
    assign cr_w    = IS_REM ? rem_crit  : loc_crit;
    assign valid_w = IS_REM ? rem_valid : loc_valid;

    limit_compare #(.TW(TW), .HW(HW)) u_cmp (
      .temp(t_w), .hi(hi_w), .lo(lo_w), .crit(cr_w), .hyst(crit_hyst), .res(cmp_w)
    );

    // diode open forces remote hot
    assign raw[K_HOT]  = cmp_w.hot | (IS_REM & rem_open);
    assign raw[K_COOL] = cmp_w.cool;
    assign raw[K_CRIT] = cmp_w.crit;

    for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
      logic f_q, cond_q, f_nxt;

      fault_filter #(.DEPTH(Q_DEPTH)) u_ff (
        .clk(clk), .rst(rst), .strobe(valid_w),
        .enable(fault_queue_en & IS_REM), .cond(raw[k]), .qual(qual[k])
      );

      assign f_nxt = (f_q & ~(status_rd & ~cond_q)) | (valid_w & qual[k]);

      always_ff @(posedge clk) begin
        if (rst) begin
          f_q    <= 1'b0;
          cond_q <= 1'b0;
        end else begin
          f_q <= f_nxt;
          if (valid_w) cond_q <= qual[k];
        end
      end

      assign flag_q[c][k]   = f_q;
      assign flag_nxt[c][k] = f_nxt;
    end

    overt_hyst u_ov (
      .clk(clk), .rst(rst), .strobe(valid_w),
      .set_in(qual[K_CRIT]), .rel_in(cmp_w.below_rel), .state_nxt(ov_nxt[c])
    );
  end

  logic alert_act, overt_act;
  assign alert_act = ~alert_mask & (|flag_nxt);
  assign overt_act = ~overt_mask & (|ov_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      alert_o <= active_low;
      overt_o <= active_low;
      open_q  <= 1'b0;
    end else begin
      alert_o <= active_low ^ alert_act;
      overt_o <= active_low ^ overt_act;
      open_q  <= rem_open;
    end
  end

  assign status = {1'b0,
                   flag_q[CH_LOC][K_HOT], flag_q[CH_LOC][K_COOL],
                   flag_q[CH_REM][K_HOT], flag_q[CH_REM][K_COOL],
                   open_q,
                   flag_q[CH_REM][K_CRIT], flag_q[CH_LOC][K_CRIT]};
endmodule

// File: rtl/thermal_alarm_checker.sv
module thermal_alarm_checker (
  input logic       clk,
  input logic       rst,
  input logic       loc_valid,
  input logic       rem_valid,
  input logic       alert_mask,
  input logic       overt_mask,
  input logic       active_low,
  input logic       status_rd,
  input logic [7:0] status,
  input logic       alert_o,
  input logic       overt_o
);
  assert_alert_mask_R6: assert property (@(posedge clk) disable iff (rst)
    alert_mask |=> (alert_o == $past(active_low)));

  assert_overt_mask_R6: assert property (@(posedge clk) disable iff (rst)
    overt_mask |=> (overt_o == $past(active_low)));

  assert_loc_set_on_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(status[6]) || $rose(status[5]) || $rose(status[0])) |-> $past(loc_valid));

  assert_rem_set_on_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(status[4]) || $rose(status[3]) || $rose(status[1])) |-> $past(rem_valid));

  assert_clear_needs_read_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(status[6]) || $fell(status[5]) || $fell(status[4]) ||
     $fell(status[3]) || $fell(status[1]) || $fell(status[0]))
    |-> ($past(status_rd) || $past(rst)));
endmodule

bind thermal_alarm_ctrl thermal_alarm_checker chk_i (
  .clk(clk), .rst(rst), .loc_valid(loc_valid), .rem_valid(rem_valid),
  .alert_mask(alert_mask), .overt_mask(overt_mask), .active_low(active_low),
  .status_rd(status_rd), .status(status), .alert_o(alert_o), .overt_o(overt_o)
);

// File: tb/thermal_alarm_ctrl_tb_top.sv
module thermal_alarm_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       loc_valid, rem_valid, rem_open;
  logic [7:0] loc_temp, rem_temp;
  logic [7:0] loc_hi, loc_lo, loc_crit, rem_hi, rem_lo, rem_crit;
  logic [4:0] crit_hyst;
  logic       alert_mask, overt_mask, fault_queue_en, active_low, status_rd;
  logic [7:0] status;
  logic       alert_o, overt_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  thermal_alarm_ctrl dut_i (
    .clk(clk), .rst(rst), .loc_valid(loc_valid), .loc_temp(loc_temp),
    .rem_valid(rem_valid), .rem_temp(rem_temp), .rem_open(rem_open),
    .loc_hi(loc_hi), .loc_lo(loc_lo), .loc_crit(loc_crit),
    .rem_hi(rem_hi), .rem_lo(rem_lo), .rem_crit(rem_crit),
    .crit_hyst(crit_hyst), .alert_mask(alert_mask), .overt_mask(overt_mask),
    .fault_queue_en(fault_queue_en), .active_low(active_low),
    .status_rd(status_rd), .status(status), .alert_o(alert_o), .overt_o(overt_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic pol);
    @(negedge clk);
    rst = 1'b1; loc_valid = 0; rem_valid = 0; rem_open = 0; status_rd = 0;
    loc_temp = 8'd25; rem_temp = 8'd25;
    loc_hi = 8'd80; loc_lo = 8'd0; rem_hi = 8'd80; rem_lo = 8'd0;
    loc_crit = 8'd85; rem_crit = 8'd110; crit_hyst = 5'd10;
    alert_mask = 0; overt_mask = 0; fault_queue_en = 0; active_low = pol;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic strobe_loc(input logic [7:0] t);
    @(negedge clk); loc_temp = t; loc_valid = 1'b1;
    @(negedge clk); loc_valid = 1'b0;
  endtask

  task automatic strobe_rem(input logic [7:0] t);
    @(negedge clk); rem_temp = t; rem_valid = 1'b1;
    @(negedge clk); rem_valid = 1'b0;
  endtask

  task automatic read_status();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk("R11 status", status, 8'h00);
    chk("R11 alert idle", alert_o, 1);
    chk("R11 overt idle", overt_o, 1);
  endtask

  task automatic t_window();
    do_reset(1'b1);
    strobe_loc(8'd80);
    chk("R1 equal high not hot", status, 8'h00);
    @(negedge clk); loc_temp = 8'd100;
    @(negedge clk);
    chk("R3 no strobe no effect", status, 8'h00);
    strobe_loc(8'd81);
    chk("R2 local hot bit6", status, 8'h40);
    chk("R10 alert active", alert_o, 0);
    loc_lo = 8'hFB;
    strobe_loc(8'hFB);
    read_status();
    chk("R1 equal low not cool", status, 8'h00);
    strobe_loc(8'hFA);
    chk("R1 signed cool bit5", status, 8'h20);
    read_status();
    chk("R4 read keeps live flag", status, 8'h20);
    strobe_loc(8'd20);
    chk("R3 flag sticky", status, 8'h20);
    read_status();
    chk("R4 read clears stale flag", status, 8'h00);
    chk("R10 alert released", alert_o, 1);
  endtask

  task automatic t_hyst();
    do_reset(1'b1);
    strobe_loc(8'd86);
    chk("R5 crit set overt", overt_o, 0);
    chk("R2 local crit bit0 with hot", status, 8'h41);
    strobe_loc(8'd80);
    read_status();
    chk("R5 overt held above release", overt_o, 0);
    strobe_loc(8'd75);
    chk("R5 overt held at release point", overt_o, 0);
    strobe_loc(8'd74);
    chk("R5 overt released", overt_o, 1);
  endtask

  task automatic t_masks();
    do_reset(1'b1);
    alert_mask = 1; overt_mask = 1;
    strobe_loc(8'd90);
    chk("R6 alert masked", alert_o, 1);
    chk("R6 overt masked", overt_o, 1);
    chk("R6 flags kept", status, 8'h41);
    @(negedge clk); alert_mask = 0; overt_mask = 0;
    @(negedge clk);
    chk("R6 alert unmasked", alert_o, 0);
    chk("R6 overt unmasked", overt_o, 0);
  endtask

  task automatic t_polarity();
    do_reset(1'b0);
    chk("R7 active-high idle alert", alert_o, 0);
    chk("R7 active-high idle overt", overt_o, 0);
    strobe_rem(8'd111);
    chk("R7 active-high alert", alert_o, 1);
    chk("R7 active-high overt", overt_o, 1);
    chk("R2 remote crit bit1 with hot", status, 8'h12);
  endtask

  task automatic t_queue();
    do_reset(1'b1);
    fault_queue_en = 1;
    strobe_rem(8'd90);
    strobe_rem(8'd90);
    chk("R8 two readings not enough", status, 8'h00);
    chk("R8 alert still idle", alert_o, 1);
    strobe_rem(8'd90);
    chk("R8 third reading sets", status, 8'h10);
    strobe_rem(8'd50);
    read_status();
    strobe_rem(8'd90);
    strobe_rem(8'd90);
    strobe_rem(8'd50);
    strobe_rem(8'd90);
    chk("R8 broken run restarts", status, 8'h00);
    strobe_loc(8'd81);
    chk("R8 local not delayed", status, 8'h40);
    do_reset(1'b1);
    strobe_rem(8'hF0);
    chk("R8 off remote cool immediate bit3", status, 8'h08);
  endtask

  task automatic t_open();
    do_reset(1'b1);
    @(negedge clk); rem_open = 1;
    strobe_rem(8'd20);
    chk("R9 open forces hot and bit2", status, 8'h14);
    chk("R9 alert from open", alert_o, 0);
    @(negedge clk); rem_open = 0;
    @(negedge clk);
    chk("R9 open bit follows input", status, 8'h10);
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_window();
    t_hyst();
    t_masks();
    t_polarity();
    t_queue();
    t_open();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule